// File: doc/BRIEF.md
# Ternary Match Array Update Engine

This block owns the storage of a ternary match array and a staging cache of the same shape as one array row. Each row consists of entry words, mask words, one type-group word, action words and counter words, all 32 bits wide. Software never touches the array directly. It fills the cache through a simple register port, writes a count register if the operation spans several rows, and then writes a control register that names an operation, a base row, optional part exclusions and a start flag. The engine carries out the operation one 32-bit word per clock and drops the start flag when the last word has moved, so software polls that flag to learn that the operation is complete.

Five operations exist: store the cache into one row, load one row into the cache, shift a block of rows toward lower row numbers, shift a block toward higher row numbers, and replicate the cache into a run of consecutive rows. Any of the three row parts (the entry part, meaning entry, mask and type-group words; the action part; and the counter part) can be excluded from an operation. A row whose type-group word is zero holds no valid rule, so the cleared state after reset marks every row as empty.

Top module: `tcam_cache_engine`

## Requirements
- R1: After reset every register reads zero, `busy` is low, and every array row reads back as all-zero words.
- R2: Register map: control at address 0x00, row count at 0x01 (bits 7:0), and cache word k at 0x10+k. Within a row, words 0-1 are entry data, 2-3 are mask data (a 1 bit means don't care), 4 is the type-group word, 5-6 are action words and 7 is the counter word. Operation code 0 copies the cache into the row named in control bits 15:8, and code 1 copies that row into the cache (opcode in control bits 2:0).
- R3: Writing control with bit 31 set while idle starts an operation; bit 31 and `busy` then stay high for exactly (rows covered x 8) clock cycles and clear on their own.
- R4: Control bit 16 excludes the entry part (words 0-4), bit 17 the action part (words 5-6) and bit 18 the counter part (word 7); an excluded word is left unchanged in both the array and the cache.
- R5: Code 4 copies the cache into the rows from the base row upward, as many as the row count register says; a count of 0 covers one row.
- R6: Code 2 processes rows in ascending order, replacing each row of the counted block with the row just above it.
- R7: Code 3 processes rows in descending order, replacing each row from base+1 to base+count with the row just below it, so every source row is read before it is overwritten.
- R8: An operation with the entry part included and a base row at or beyond the number of rows, and any opcode above 4, changes nothing and holds `busy` for a single cycle.
- R9: A control write while `busy` is high is ignored: the running operation, its length and the control read-back value are unaffected.
- R10: When the engine stores a word into the cache in the same cycle as a software write to that cache word, the engine value is kept.
- R11: During a multi-row operation, a destination row beyond the array is skipped, and a source row beyond the array supplies zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for the word at `regAddr`, combinational |
| busy | output | 1 | High while an operation is running (mirror of control bit 31) |

## Verification
The one place where two agents act on the same storage in one cycle is the cache: a row load writes cache words one per clock while software may write the same word through the register port. The bench launches a load and times a software write so that it lands on the exact cycle in which the engine stores that word, then reads the cache after completion and expects the array value. A second overlap, a control write arriving during a running operation, is provoked by issuing a new start mid-run and judged by the unchanged busy length and control read-back, both compared against the reference model every clock.

// File: rtl/tcam_upd_pkg.sv
package tcam_upd_pkg;

  localparam int ROW_IX_W  = 10;
  localparam int WORD_IX_W = 8;

  localparam logic [7:0] REG_CTRL       = 8'h00;
  localparam logic [7:0] REG_MVCNT      = 8'h01;
  localparam logic [7:0] REG_CACHE_BASE = 8'h10;

  localparam int BIT_START    = 31;
  localparam int BIT_DIS_ENT  = 16;
  localparam int BIT_DIS_ACT  = 17;
  localparam int BIT_DIS_CNT  = 18;

  typedef enum logic [2:0] {
    CMD_WRITE = 3'd0,
    CMD_READ  = 3'd1,
    CMD_MVUP  = 3'd2,
    CMD_MVDN  = 3'd3,
    CMD_INIT  = 3'd4
  } cmd_e;

  typedef struct packed {
    logic                 cacheToArr;
    logic                 arrToCache;
    logic                 arrToArr;
    logic                 srcOk;
    logic                 dstOk;
    logic [ROW_IX_W-1:0]  srcRow;
    logic [ROW_IX_W-1:0]  dstRow;
    logic [WORD_IX_W-1:0] wordIx;
  } stb_t;

endpackage

// File: rtl/tcam_upd_ctrl.sv
module tcam_upd_ctrl
  import tcam_upd_pkg::*;
#(
  parameter int NUM_ROWS     = 16,
  parameter int ROW_WORDS    = 8,
  parameter int ENTRY_PART   = 5,
  parameter int ACTION_WORDS = 2,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      ctrlWord,
  output logic [CNT_W-1:0] moveCnt,
  output stb_t             stb
);

  localparam logic [ROW_IX_W-1:0]  ROW_LIM   = ROW_IX_W'(NUM_ROWS);
  localparam logic [WORD_IX_W-1:0] LAST_WORD = WORD_IX_W'(ROW_WORDS - 1);
  localparam logic [WORD_IX_W-1:0] ACT_START = WORD_IX_W'(ENTRY_PART);
  localparam logic [WORD_IX_W-1:0] CNT_START = WORD_IX_W'(ENTRY_PART + ACTION_WORDS);

  logic [2:0]           cmdQ;
  logic [7:0]           rowQ;
  logic [2:0]           disQ;
  logic                 startQ;
  logic                 abortQ;
  logic [ROW_IX_W-1:0]  stepQ;
  logic [ROW_IX_W-1:0]  nRowsQ;
  logic [WORD_IX_W-1:0] wordQ;

  logic                 ctrlWr;
  logic                 newMulti;
  logic                 newAbort;
  logic [ROW_IX_W-1:0]  effCnt;
  logic [ROW_IX_W-1:0]  newRows;

  assign ctrlWr   = regWe && (regAddr == REG_CTRL);
  assign effCnt   = (moveCnt == '0) ? ROW_IX_W'(1) : ROW_IX_W'(moveCnt);
  assign newMulti = (regWdata[2:0] == CMD_MVUP) || (regWdata[2:0] == CMD_MVDN) ||
                    (regWdata[2:0] == CMD_INIT);
  assign newRows  = newMulti ? effCnt : ROW_IX_W'(1);
  assign newAbort = (!regWdata[BIT_DIS_ENT] && ({2'b00, regWdata[15:8]} >= ROW_LIM)) ||
                    (regWdata[2:0] > 3'd4);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      moveCnt <= '0;
    end else if (regWe && (regAddr == REG_MVCNT)) begin
      moveCnt <= regWdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ   <= '0;
      rowQ   <= '0;
      disQ   <= '0;
      startQ <= 1'b0;
      abortQ <= 1'b0;
      stepQ  <= '0;
      nRowsQ <= '0;
      wordQ  <= '0;
    end else if (ctrlWr && !startQ) begin
      cmdQ   <= regWdata[2:0];
      rowQ   <= regWdata[15:8];
      disQ   <= regWdata[BIT_DIS_CNT:BIT_DIS_ENT];
      startQ <= regWdata[BIT_START];
      abortQ <= newAbort;
      stepQ  <= '0;
      nRowsQ <= newRows;
      wordQ  <= '0;
    end else if (startQ) begin
      if (abortQ) begin
        startQ <= 1'b0;
      end else if (wordQ == LAST_WORD) begin
        wordQ <= '0;
        if (stepQ == nRowsQ - ROW_IX_W'(1)) begin
          startQ <= 1'b0;
        end else begin
          stepQ <= stepQ + ROW_IX_W'(1);
        end
      end else begin
        wordQ <= wordQ + WORD_IX_W'(1);
      end
    end
  end

  assign ctrlWord = {startQ, 12'b0, disQ, rowQ, 5'b0, cmdQ};

  logic [ROW_IX_W-1:0] baseRow, srcRow, dstRow;
  logic c2a, a2c, a2a, partOn, act;

  always_comb begin
    baseRow = {2'b00, rowQ};
    srcRow  = '0;
    dstRow  = '0;
    c2a     = 1'b0;
    a2c     = 1'b0;
    a2a     = 1'b0;
    case (cmdQ)
      CMD_WRITE: begin dstRow = baseRow;          c2a = 1'b1; end
      CMD_READ:  begin srcRow = baseRow;          a2c = 1'b1; end
      CMD_INIT:  begin dstRow = baseRow + stepQ;  c2a = 1'b1; end
      CMD_MVUP: begin
        dstRow = baseRow + stepQ;
        srcRow = dstRow + ROW_IX_W'(1);
        a2a    = 1'b1;
      end
      CMD_MVDN: begin
        dstRow = baseRow + nRowsQ - stepQ;
        srcRow = dstRow - ROW_IX_W'(1);
        a2a    = 1'b1;
      end
      default: ;
    endcase

    if (wordQ < ACT_START)      partOn = !disQ[0];
    else if (wordQ < CNT_START) partOn = !disQ[1];
    else                        partOn = !disQ[2];

    act            = startQ && !abortQ && partOn;
    stb.cacheToArr = act && c2a;
    stb.arrToCache = act && a2c;
    stb.arrToArr   = act && a2a;
    stb.srcOk      = srcRow < ROW_LIM;
    stb.dstOk      = dstRow < ROW_LIM;
    stb.srcRow     = srcRow;
    stb.dstRow     = dstRow;
    stb.wordIx     = wordQ;
  end

endmodule

// File: rtl/tcam_upd_dp.sv
module tcam_upd_dp
  import tcam_upd_pkg::*;
#(
  parameter int NUM_ROWS  = 16,
  parameter int ROW_WORDS = 8,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWdata,
  input  stb_t             stb,
  input  logic [31:0]      ctrlWord,
  input  logic [CNT_W-1:0] moveCnt,
  output logic [31:0]      regRdata
);

  localparam int RA_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int WA_W = (ROW_WORDS > 1) ? $clog2(ROW_WORDS) : 1;

  logic [31:0] cacheQ [ROW_WORDS];
  logic [31:0] arrQ   [NUM_ROWS][ROW_WORDS];

  logic [RA_W-1:0] srcIx, dstIx;
  logic [WA_W-1:0] wIx;
  logic [31:0]     srcWord, arrData;
  logic            arrWr;

  assign srcIx   = stb.srcRow[RA_W-1:0];
  assign dstIx   = stb.dstRow[RA_W-1:0];
  assign wIx     = stb.wordIx[WA_W-1:0];
  assign srcWord = stb.srcOk ? arrQ[srcIx][wIx] : 32'h0;
  assign arrWr   = (stb.cacheToArr || stb.arrToArr) && stb.dstOk;
  assign arrData = stb.cacheToArr ? cacheQ[wIx] : srcWord;

  generate
    for (genvar k = 0; k < ROW_WORDS; k++) begin : g_cache
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cacheQ[k] <= '0;
        end else if (stb.arrToCache && (wIx == WA_W'(k))) begin
          cacheQ[k] <= srcWord;
        end else if (regWe && (regAddr == 8'(REG_CACHE_BASE + k))) begin
          cacheQ[k] <= regWdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_ROWS; r++) begin
        for (int w = 0; w < ROW_WORDS; w++) begin
          arrQ[r][w] <= '0;
        end
      end
    end else if (arrWr) begin
      arrQ[dstIx][wIx] <= arrData;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == REG_CTRL) regRdata = ctrlWord;
    if (regAddr == REG_MVCNT) regRdata = 32'(moveCnt);
    for (int k = 0; k < ROW_WORDS; k++) begin
      if (regAddr == 8'(REG_CACHE_BASE + k)) regRdata = cacheQ[k];
    end
  end

endmodule

// File: rtl/tcam_cache_engine.sv
module tcam_cache_engine
  import tcam_upd_pkg::*;
#(
  parameter int NUM_ROWS      = 16,
  parameter int ENTRY_WORDS   = 2,
  parameter int ACTION_WORDS  = 2,
  parameter int COUNTER_WORDS = 1,
  parameter int CNT_W         = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        busy
);

  localparam int ENTRY_PART = 2 * ENTRY_WORDS + 1;
  localparam int ROW_WORDS  = ENTRY_PART + ACTION_WORDS + COUNTER_WORDS;

  stb_t             stb;
  logic [31:0]      ctrlWord;
  logic [CNT_W-1:0] moveCnt;

  tcam_upd_ctrl #(
    .NUM_ROWS(NUM_ROWS), .ROW_WORDS(ROW_WORDS), .ENTRY_PART(ENTRY_PART),
    .ACTION_WORDS(ACTION_WORDS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .ctrlWord(ctrlWord), .moveCnt(moveCnt), .stb(stb)
  );

  tcam_upd_dp #(
    .NUM_ROWS(NUM_ROWS), .ROW_WORDS(ROW_WORDS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .stb(stb), .ctrlWord(ctrlWord), .moveCnt(moveCnt), .regRdata(regRdata)
  );

  assign busy = ctrlWord[BIT_START];

endmodule

// File: rtl/tcam_cache_engine_chk.sv
module tcam_cache_engine_chk
  import tcam_upd_pkg::*;
#(
  parameter int NUM_ROWS   = 16,
  parameter int ENTRY_PART = 5
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [7:0]  regAddr,
  input logic [31:0] regWdata,
  input logic        busy,
  input logic [31:0] ctrlWord,
  input stb_t        stb
);

  localparam logic [8:0]           ROW_LIM   = 9'(NUM_ROWS);
  localparam logic [WORD_IX_W-1:0] ENT_LIMIT = WORD_IX_W'(ENTRY_PART);

  logic anyStb, launchReq, ctrlWr;
  assign anyStb    = stb.cacheToArr || stb.arrToCache || stb.arrToArr;
  assign ctrlWr    = regWe && (regAddr == REG_CTRL);
  assign launchReq = ctrlWr && regWdata[BIT_START] && !busy;

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    launchReq |=> busy);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !anyStb);

  // R2
  one_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cacheToArr, stb.arrToCache, stb.arrToArr}));

  // R8
  oob_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (launchReq && !regWdata[BIT_DIS_ENT] && ({1'b0, regWdata[15:8]} >= ROW_LIM))
      |=> !anyStb);

  // R4
  entry_dis_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anyStb && ctrlWord[BIT_DIS_ENT]) |-> (stb.wordIx >= ENT_LIMIT));

  // R9
  busy_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlWr) |=> (ctrlWord[30:0] == $past(ctrlWord[30:0])));

endmodule

bind tcam_cache_engine tcam_cache_engine_chk #(
  .NUM_ROWS(NUM_ROWS), .ENTRY_PART(ENTRY_PART)
) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .busy(busy), .ctrlWord(ctrlWord), .stb(stb)
);

// File: tb/sim_tcam_cache_engine.sv
module sim_tcam_cache_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 16;
  localparam int RW = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWdata = 32'h0;
  logic [31:0] regRdata;
  logic        busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcam_cache_engine u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy)
  );

  // reference model state
  logic [31:0] mArr [NR][RW];
  logic [31:0] mCache [RW];
  logic [2:0]  mCmd;
  logic [7:0]  mRow;
  logic [2:0]  mDis;
  logic        mStart;
  logic [7:0]  mCnt;
  int          mLeft;

  int    nCmp = 0;
  int    nBad = 0;
  string curReq = "R1";
  bit    cmpOn = 1'b0;

  function automatic int partOf(int k);
    return (k < 5) ? 0 : ((k < 7) ? 1 : 2);
  endfunction

  function automatic bit isAbort(logic [2:0] c, logic [7:0] r, logic [2:0] d);
    return (!d[0] && (int'(r) >= NR)) || (c > 3'd4);
  endfunction

  function automatic int rowsOf(logic [2:0] c, logic [7:0] cnt);
    if (c == 3'd2 || c == 3'd3 || c == 3'd4) return (cnt == 0) ? 1 : int'(cnt);
    return 1;
  endfunction

  function automatic logic [31:0] pat(int s, int k);
    return (32'(s) * 32'h0100_0193) ^ (32'(k) * 32'h0001_0101) ^ 32'hC3C3_0000;
  endfunction

  task automatic applyCmd();
    int nR;
    nR = rowsOf(mCmd, mCnt);
    if (isAbort(mCmd, mRow, mDis)) return;
    for (int s = 0; s < nR; s++) begin
      for (int k = 0; k < RW; k++) begin
        if (!mDis[partOf(k)]) begin
          int d;
          int sv;
          case (mCmd)
            3'd0: if (int'(mRow) < NR) mArr[mRow][k] = mCache[k];
            3'd1: mCache[k] = (int'(mRow) < NR) ? mArr[mRow][k] : 32'h0;
            3'd4: begin
              d = int'(mRow) + s;
              if (d < NR) mArr[d][k] = mCache[k];
            end
            3'd2: begin
              d = int'(mRow) + s;
              sv = d + 1;
              if (d < NR) mArr[d][k] = (sv < NR) ? mArr[sv][k] : 32'h0;
            end
            3'd3: begin
              d = int'(mRow) + nR - s;
              sv = d - 1;
              if (d < NR) mArr[d][k] = (sv < NR) ? mArr[sv][k] : 32'h0;
            end
            default: ;
          endcase
        end
      end
    end
  endtask

  always @(posedge clk) begin : model
    bit wasBusy;
    if (!rstN) begin
      for (int r = 0; r < NR; r++) for (int k = 0; k < RW; k++) mArr[r][k] = 32'h0;
      for (int k = 0; k < RW; k++) mCache[k] = 32'h0;
      mCmd = 0; mRow = 0; mDis = 0; mStart = 0; mCnt = 0; mLeft = 0;
    end else begin
      wasBusy = mStart;
      if (regWe) begin
        if (regAddr == 8'h00) begin
          if (!mStart) begin
            mCmd   = regWdata[2:0];
            mRow   = regWdata[15:8];
            mDis   = regWdata[18:16];
            mStart = regWdata[31];
            if (mStart)
              mLeft = isAbort(mCmd, mRow, mDis) ? 1 : rowsOf(mCmd, mCnt) * RW;
          end
        end else if (regAddr == 8'h01) begin
          mCnt = regWdata[7:0];
        end else if (regAddr >= 8'h10 && int'(regAddr) < 16 + RW) begin
          mCache[int'(regAddr) - 16] = regWdata;
        end
      end
      if (wasBusy) begin
        mLeft--;
        if (mLeft == 0) begin
          applyCmd();
          mStart = 1'b0;
        end
      end
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s addr=%02h actual=%08h expected=%08h t=%0t",
               curReq, what, regAddr, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin : compare
    logic [31:0] exp;
    bit doData;
    if (cmpOn) begin
      check("busy", 32'(busy), 32'(mStart));
      doData = 1'b1;
      exp = 32'h0;
      if (regAddr == 8'h00) exp = {mStart, 12'b0, mDis, mRow, 5'b0, mCmd};
      else if (regAddr == 8'h01) exp = 32'(mCnt);
      else if (regAddr >= 8'h10 && int'(regAddr) < 16 + RW) begin
        exp = mCache[int'(regAddr) - 16];
        doData = !mStart;
      end
      if (doData) check("rdata", regRdata, exp);
    end
  end

  task automatic cyc(bit we, logic [7:0] a, logic [31:0] d);
    regWe = we; regAddr = a; regWdata = d;
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cyc(1'b1, a, d);
  endtask

  task automatic launch(logic [2:0] c, logic [7:0] row, logic [2:0] dis);
    wr(8'h00, {1'b1, 12'b0, dis, row, 5'b0, c});
  endtask

  task automatic waitDone();
    while (mStart) cyc(1'b0, 8'h00, 32'h0);
    cyc(1'b0, 8'h00, 32'h0);
  endtask

  task automatic runCmd(logic [2:0] c, logic [7:0] row, logic [2:0] dis);
    launch(c, row, dis);
    waitDone();
  endtask

  task automatic sweep();
    for (int k = 0; k < RW; k++) cyc(1'b0, 8'(16 + k), 32'h0);
    cyc(1'b0, 8'h00, 32'h0);
    cyc(1'b0, 8'h01, 32'h0);
  endtask

  task automatic fillCache(int seed);
    for (int k = 0; k < RW; k++) wr(8'(16 + k), pat(seed, k));
  endtask

  task automatic clearCache();
    for (int k = 0; k < RW; k++) wr(8'(16 + k), 32'h0);
  endtask

  task automatic showRow(int r);
    runCmd(3'd1, 8'(r), 3'b000);
    sweep();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL R3 watchdog actual=still running expected=finished");
    summary();
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    cmpOn = 1'b1;

    // R1: reset state of registers and array
    curReq = "R1";
    sweep();
    showRow(5);
    showRow(15);

    // R2: store and load of single rows
    curReq = "R2";
    fillCache(1);
    runCmd(3'd0, 8'd3, 3'b000);
    clearCache();
    showRow(3);
    fillCache(2);
    runCmd(3'd0, 8'd0, 3'b000);
    showRow(0);

    // R3: start flag self-clears after rows x 8 cycles
    curReq = "R3";
    fillCache(4);
    runCmd(3'd0, 8'd7, 3'b000);
    showRow(7);

    // R4: part exclusion on store and load
    curReq = "R4";
    fillCache(5);
    runCmd(3'd0, 8'd3, 3'b001);
    showRow(3);
    fillCache(6);
    runCmd(3'd1, 8'd3, 3'b100);
    sweep();
    runCmd(3'd0, 8'd2, 3'b110);
    showRow(2);

    // R5: replicate cache over a run of rows, count 0 means one row
    curReq = "R5";
    wr(8'h01, 32'd4);
    fillCache(7);
    runCmd(3'd4, 8'd8, 3'b000);
    for (int r = 7; r <= 12; r++) showRow(r);
    wr(8'h01, 32'd0);
    fillCache(8);
    runCmd(3'd4, 8'd14, 3'b000);
    showRow(13);
    showRow(14);
    showRow(15);

    // R6: ascending shift
    curReq = "R6";
    fillCache(9);
    runCmd(3'd0, 8'd15, 3'b000);
    fillCache(12);
    runCmd(3'd0, 8'd11, 3'b000);
    wr(8'h01, 32'd3);
    runCmd(3'd2, 8'd8, 3'b000);
    for (int r = 8; r <= 11; r++) showRow(r);

    // R11: ascending shift at the top edge of the array
    curReq = "R11";
    runCmd(3'd2, 8'd14, 3'b000);
    showRow(14);
    showRow(15);

    // R7: descending shift
    curReq = "R7";
    wr(8'h01, 32'd3);
    runCmd(3'd3, 8'd2, 3'b000);
    for (int r = 2; r <= 6; r++) showRow(r);

    // R11: descending shift with destinations beyond the array
    curReq = "R11";
    fillCache(13);
    runCmd(3'd0, 8'd14, 3'b000);
    runCmd(3'd3, 8'd14, 3'b000);
    showRow(14);
    showRow(15);

    // R8: out-of-range row with entry part, and unknown opcode
    curReq = "R8";
    fillCache(10);
    runCmd(3'd0, 8'd20, 3'b000);
    runCmd(3'd6, 8'd1, 3'b000);
    runCmd(3'd0, 8'd200, 3'b001);
    for (int r = 0; r < NR; r++) showRow(r);
    fillCache(14);
    runCmd(3'd1, 8'd20, 3'b001);
    sweep();

    // R9: control write during a running operation
    curReq = "R9";
    fillCache(15);
    launch(3'd0, 8'd0, 3'b000);
    cyc(1'b0, 8'h00, 32'h0);
    wr(8'h00, {1'b1, 12'b0, 3'b000, 8'd9, 5'b0, 3'd0});
    waitDone();
    showRow(9);
    showRow(0);

    // R10: engine cache store collides with software cache write
    curReq = "R10";
    fillCache(11);
    runCmd(3'd0, 8'd1, 3'b000);
    clearCache();
    launch(3'd1, 8'd1, 3'b000);
    cyc(1'b0, 8'h00, 32'h0);
    cyc(1'b0, 8'h00, 32'h0);
    wr(8'h12, 32'hDEAD_BEEF);
    waitDone();
    sweep();

    cyc(1'b0, 8'h00, 32'h0);
    summary();
    $finish;
  end

endmodule